// File: doc/BRIEF.md
# Expansion RAM Auto-Configuration Responder

This block answers the configuration probe of an expansion RAM card sitting on a 16-bit processor bus. While the card is still unconfigured and the host selects the configuration window, the block returns identification data, one 4-bit nibble per access. Each logical byte is split across two neighbouring even addresses, and each nibble is carried on the top four data lines. The host reads the card type, the memory size code and the maker code. It then either assigns a base address or tells the card to stay quiet.

A base-address write does two things at once. It publishes the base and the size code to the system region decoder, and it retires the responder. A quiet write retires the responder without publishing anything. Once retired, the block ignores every access until the next reset. The amount of fitted RAM is a parameter. With no RAM fitted, the responder is silent from reset onward.

Top module: `xram_autocfg`

## Requirements
- R1: After reset, `ack`, `rdDataEn`, `mapStb` and `mapValid` are 0. The responder is answering only when `RAM_MB` is nonzero; a card built with `RAM_MB`=0 never acknowledges.
- R2: A read is an access with `cfgSel`=1 and `rdStb`=1 while the responder is answering. One clock later `ack`=1 and `rdDataEn`=1. `rdData` then equals {nibble, 12'hFFF}, with the nibble on bits 15..12.
- R3: Byte offset 0x00, which is {addr,1'b0}, reads nibble 0xE. This marks a bus-II style memory card whose RAM is added to the free pool.
- R4: Byte offset 0x02 reads the size code: 5 for 1 MB, 6 for 2 MB, 7 for 4 MB and 0 for 8 MB.
- R5: Offsets 0x10 and 0x12 read nibble 0xA. Offsets 0x14 and 0x16 read nibble 0xB.
- R6: Every other offset reads nibble 0xF. A write to an offset outside 0x48 and 0x4C..0x4F is acknowledged and has no other effect.
- R7: A write to offset 0x48 has three results one clock later. `mapStb` pulses high for exactly one cycle. `mapBase` takes `wrDataHi` as address bits 23..16, and `mapSize` carries the size code. `mapValid` then stays 1 until reset, and the responder stops answering.
- R8: A write to offset 0x4C or 0x4E stops the responder without raising `mapStb` or `mapValid`.
- R9: While the responder is not answering, an access produces no `ack`, no `rdDataEn` and no `mapStb`.
- R10: With `cfgSel`=0, strobes produce no `ack` and no other effect.
- R11: Reset makes a fitted responder answer again and clears `mapValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSel | input | 1 | Configuration window selected |
| addr | input | 7 | Address bits 7..1 |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe (ignored when rdStb is set) |
| wrDataHi | input | 8 | Write data, lines 15..8 |
| rdData | output | 16 | Read data, zero when not driven |
| rdDataEn | output | 1 | Read data drive enable |
| ack | output | 1 | Access acknowledge |
| mapStb | output | 1 | One-cycle mapping strobe |
| mapBase | output | 8 | Assigned base, address bits 23..16 |
| mapSize | output | 4 | Size code of the mapped RAM |
| mapValid | output | 1 | RAM region has been mapped |

## Verification
Every result is registered once. `ack`, `rdDataEn`, `rdData`, `mapStb` and `mapBase` are therefore due on the first rising edge after the cycle that presents the strobe. A change of answering state shows on the access after that. The bench drives each access from the falling edge and samples 1 ns after the next rising edge. It then checks one more cycle later that `ack` and `mapStb` have fallen. Silence after retirement, after a quiet write or with `cfgSel` low is judged from `ack` and `rdDataEn` on a follow-up read, sampled in that same slot.

// File: rtl/xram_cfg_pkg.sv
package xram_cfg_pkg;

  typedef struct packed {
    logic ldRead;   // capture a read nibble
    logic ldBase;   // capture base, publish mapping
  } cfgStrobes_t;

  function automatic logic [3:0] sizeCode(input int mb);
    case (mb)
      1:       return 4'd5;
      2:       return 4'd6;
      4:       return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] idNibble(input logic [6:0] a, input logic [3:0] sz);
    case (a)
      7'h00:                return 4'hE;
      7'h01:                return sz;
      7'h08, 7'h09:         return 4'hA;
      7'h0A, 7'h0B:         return 4'hB;
      default:              return 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/xram_cfg_ctrl.sv
module xram_cfg_ctrl
  import xram_cfg_pkg::*;
#(
  parameter bit FITTED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSel,
  input  logic [6:0]  addr,
  input  logic        rdStb,
  input  logic        wrStb,
  output cfgStrobes_t strb,
  output logic        visible,
  output logic        ack
);
  localparam logic [6:0] BASE_SLOT  = 7'h24;  // byte 0x48
  localparam logic [5:0] QUIET_SLOT = 6'h13;  // bytes 0x4C..0x4F

  logic visibleQ, ackQ;
  logic access, isRead, isWrite, baseHit, quietHit;

  always_comb begin
    access   = visibleQ && cfgSel && (rdStb || wrStb);
    isRead   = access && rdStb;
    isWrite  = access && !rdStb;
    baseHit  = isWrite && (addr == BASE_SLOT);
    quietHit = isWrite && (addr[6:1] == QUIET_SLOT);
    strb.ldRead = isRead;
    strb.ldBase = baseHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visibleQ <= FITTED;
      ackQ     <= 1'b0;
    end else begin
      ackQ <= access;
      if (baseHit || quietHit) visibleQ <= 1'b0;
    end
  end

  assign visible = visibleQ;
  assign ack     = ackQ;
endmodule

// File: rtl/xram_cfg_dp.sv
module xram_cfg_dp
  import xram_cfg_pkg::*;
#(
  parameter logic [3:0] SIZE_CODE = 4'd6,
  parameter int         NIB_W     = 4,
  parameter int         BUS_W     = 16,
  localparam int        FILL_W    = BUS_W - NIB_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobes_t      strb,
  input  logic [6:0]       addr,
  input  logic [7:0]       wrDataHi,
  output logic [BUS_W-1:0] rdData,
  output logic             rdDataEn,
  output logic             mapStb,
  output logic [7:0]       mapBase,
  output logic             mapValid
);
  logic [NIB_W-1:0] nibQ;
  logic             rdEnQ, mapStbQ, mapValidQ;
  logic [7:0]       baseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibQ      <= '0;
      rdEnQ     <= 1'b0;
      mapStbQ   <= 1'b0;
      mapValidQ <= 1'b0;
      baseQ     <= '0;
    end else begin
      rdEnQ   <= strb.ldRead;
      mapStbQ <= strb.ldBase;
      if (strb.ldRead) nibQ <= idNibble(addr, SIZE_CODE);
      if (strb.ldBase) begin
        baseQ     <= wrDataHi;
        mapValidQ <= 1'b1;
      end
    end
  end

  assign rdData   = rdEnQ ? {nibQ, {FILL_W{1'b1}}} : '0;
  assign rdDataEn = rdEnQ;
  assign mapStb   = mapStbQ;
  assign mapBase  = baseQ;
  assign mapValid = mapValidQ;
endmodule

// File: rtl/xram_autocfg.sv
module xram_autocfg
  import xram_cfg_pkg::*;
#(
  parameter int RAM_MB = 2,
  localparam bit         FITTED = (RAM_MB != 0),
  localparam logic [3:0] SZ     = sizeCode(RAM_MB)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSel,
  input  logic [6:0]  addr,
  input  logic        rdStb,
  input  logic        wrStb,
  input  logic [7:0]  wrDataHi,
  output logic [15:0] rdData,
  output logic        rdDataEn,
  output logic        ack,
  output logic        mapStb,
  output logic [7:0]  mapBase,
  output logic [3:0]  mapSize,
  output logic        mapValid
);
  cfgStrobes_t strb;
  logic        visible;

  xram_cfg_ctrl #(.FITTED(FITTED)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .addr(addr),
    .rdStb(rdStb), .wrStb(wrStb), .strb(strb), .visible(visible), .ack(ack)
  );

  xram_cfg_dp #(.SIZE_CODE(SZ)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrDataHi(wrDataHi),
    .rdData(rdData), .rdDataEn(rdDataEn), .mapStb(mapStb),
    .mapBase(mapBase), .mapValid(mapValid)
  );

  assign mapSize = SZ;
endmodule

// File: rtl/xram_autocfg_chk.sv
module xram_autocfg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgSel,
  input logic        rdStb,
  input logic        wrStb,
  input logic        visible,
  input logic [15:0] rdData,
  input logic        rdDataEn,
  input logic        ack,
  input logic        mapStb,
  input logic        mapValid
);
  p_read_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (visible && cfgSel && rdStb) |=> (ack && rdDataEn));
  p_fill_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdDataEn |-> (rdData[11:0] == 12'hFFF));
  p_map_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    mapStb |=> !mapStb);
  p_map_retires_r7: assert property (@(posedge clk) disable iff (!rstN)
    mapStb |-> (!visible && mapValid));
  p_valid_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    mapValid |=> mapValid);
  p_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    !visible |=> (!ack && !rdDataEn && !mapStb));
  p_unselected_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSel |=> !ack);
endmodule

bind xram_autocfg xram_autocfg_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .rdStb(rdStb), .wrStb(wrStb),
  .visible(visible), .rdData(rdData), .rdDataEn(rdDataEn), .ack(ack),
  .mapStb(mapStb), .mapValid(mapValid)
);

// File: tb/xram_autocfg_tb_top.sv
`timescale 1ns/1ps
module xram_autocfg_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wrDataHi = '0;
  logic [15:0] rdData, rdData0;
  logic rdDataEn, ack, mapStb, mapValid;
  logic rdDataEn0, ack0, mapStb0, mapValid0;
  logic [7:0] mapBase, mapBase0;
  logic [3:0] mapSize, mapSize0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xram_autocfg #(.RAM_MB(2)) dut_i (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .addr(addr), .rdStb(rdStb),
    .wrStb(wrStb), .wrDataHi(wrDataHi), .rdData(rdData), .rdDataEn(rdDataEn),
    .ack(ack), .mapStb(mapStb), .mapBase(mapBase), .mapSize(mapSize),
    .mapValid(mapValid));

  xram_autocfg #(.RAM_MB(0)) none_i (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .addr(addr), .rdStb(rdStb),
    .wrStb(wrStb), .wrDataHi(wrDataHi), .rdData(rdData0), .rdDataEn(rdDataEn0),
    .ack(ack0), .mapStb(mapStb0), .mapBase(mapBase0), .mapSize(mapSize0),
    .mapValid(mapValid0));

  // {byte offset, expected nibble}
  localparam logic [7:0] VEC [12] = '{
    8'h00, 8'h0E,  8'h02, 8'h06,  8'h10, 8'h0A,
    8'h12, 8'h0A,  8'h14, 8'h0B,  8'h16, 8'h0B};
  localparam logic [7:0] OTHER [5] = '{8'h04, 8'h18, 8'h48, 8'h4C, 8'hFE};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access cycle; samples 1 ns after the capturing edge
  task automatic access(input bit sel, input bit rd, input bit wr,
                        input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfgSel = sel; rdStb = rd; wrStb = wr; addr = off[7:1]; wrDataHi = d;
    @(posedge clk); #1;
    cfgSel = 1'b0; rdStb = 1'b0; wrStb = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 ack", ack, 0); chk("R1 rdDataEn", rdDataEn, 0);
    chk("R1 mapStb", mapStb, 0); chk("R1 mapValid", mapValid, 0);

    for (int i = 0; i < 6; i++) begin
      access(1, 1, 0, VEC[2*i], 8'h00);
      chk(i == 0 ? "R3" : (i == 1 ? "R4" : "R5"), rdData, {VEC[2*i+1][3:0], 12'hFFF});
      chk("R2 ack", {ack, rdDataEn}, 2'b11);
      chk("R1 unfitted silent", {ack0, rdDataEn0}, 2'b00);
    end
    for (int i = 0; i < 5; i++) begin
      access(1, 1, 0, OTHER[i], 8'h00);
      chk("R6 other", rdData, 16'hFFFF);
    end
    @(posedge clk); #1;
    chk("R2 ack falls", ack, 0);
    chk("R4 size port", mapSize, 4'd6);

    access(0, 1, 0, 8'h00, 8'h00);
    chk("R10 no ack", {ack, rdDataEn}, 2'b00);
    access(0, 0, 1, 8'h48, 8'h55);
    chk("R10 no map", {mapStb, mapValid}, 2'b00);
    access(1, 1, 0, 8'h00, 8'h00);
    chk("R10 still answering", ack, 1);

    access(1, 0, 1, 8'h20, 8'h33);
    chk("R6 write ack", {ack, mapStb}, 2'b10);
    access(1, 1, 0, 8'h02, 8'h00);
    chk("R6 still answering", rdData, 16'h6FFF);

    access(1, 0, 1, 8'h48, 8'h20);
    chk("R7 strobe", mapStb, 1); chk("R7 base", mapBase, 8'h20);
    chk("R7 size", mapSize, 4'd6); chk("R7 valid", mapValid, 1);
    chk("R1 unfitted no map", mapStb0, 0);
    @(posedge clk); #1;
    chk("R7 one cycle", mapStb, 0); chk("R7 valid held", mapValid, 1);
    access(1, 1, 0, 8'h00, 8'h00);
    chk("R9 read silent", {ack, rdDataEn, rdData}, 18'h0);
    access(1, 0, 1, 8'h48, 8'h40);
    chk("R9 write silent", {ack, mapStb, mapBase}, 10'h020);

    doReset(); #1;
    chk("R11 valid cleared", mapValid, 0);
    access(1, 1, 0, 8'h00, 8'h00);
    chk("R11 answering", {ack, rdData}, 17'h1EFFF);

    access(1, 0, 1, 8'h4C, 8'h77);
    chk("R8 quiet 4C", {ack, mapStb, mapValid}, 3'b100);
    access(1, 1, 0, 8'h00, 8'h00);
    chk("R8 silent after 4C", {ack, rdDataEn}, 2'b00);

    doReset();
    access(1, 0, 1, 8'h4E, 8'h77);
    chk("R8 quiet 4E", {mapStb, mapValid}, 2'b00);
    access(1, 1, 0, 8'h14, 8'h00);
    chk("R8 silent after 4E", ack, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule